// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is the transmit side of a half-duplex synchronous serial port working as bus master. It drives both a bit clock line and a data line. Software places a byte in a one-entry holding buffer. An internal shift register, which software cannot reach, takes the byte once the frame in flight has sent its final bit. The byte then goes out least significant bit first. Each data bit is set up while the clock line is low and stays stable across the clock's rising edge.

There are two flags. A buffer-empty flag tells software it may write again, and it feeds an interrupt through an enable mask. A shift-register-empty status has no interrupt path and is meant to be polled. An optional ninth bit can be added to each frame. The bit rate comes from a programmable divider. While a frame is on the wire, the block tells the receive side to hold off. While the receive side reports that it is busy, no new frame starts.

Top module: `sync_master_tx`

## Requirements
- R1: A frame starts only while `sync_mode`, `port_en`, `clk_master` and `tx_en` are all 1. If any of them is 0, a written byte stays in the buffer and `ser_clk` remains low.
- R2: The bits of a frame are presented on `ser_data` least significant bit first. One bit is sampled on each rising edge of `ser_clk`, and `ser_data` does not change in the cycle in which `ser_clk` rises.
- R3: Within a frame, every high phase and every low phase of `ser_clk` lasts 2*(`div_val`+1) system clocks, so one bit time is 4*(`div_val`+1) clocks. Outside a frame `ser_clk` stays low.
- R4: `buf_empty` is 1 after reset. After a write sampled at clock edge k, `buf_empty` still shows its previous value following edge k and reads 0 following edge k+1. Only a write clears it.
- R5: The buffer moves into the shift register in one clock, and only while no frame is in progress. A byte written during a frame waits, with `buf_empty` at 0, until that frame ends. `buf_empty` returns to 1 one clock after the move.
- R6: `irq` equals `buf_empty` AND `irq_en` at all times.
- R7: `shift_empty` is 1 whenever no frame is in progress and 0 from the clock after the buffer-to-shift move until the final bit's high phase ends.
- R8: When `ninth_en` is 1 at the start of a frame, a ninth bit follows the 8 data bits. Its value is `ninth_bit` as sampled at the time of the buffer write, not at the time of sending.
- R9: Driving `tx_en` to 0 aborts the frame in progress. From the next clock `shift_empty` is 1 and `ser_clk` is 0. A byte waiting in the buffer is kept and is sent after `tx_en` returns to 1.
- R10: `rx_block` is 1 exactly while a frame is in progress, and no frame starts while `rx_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | Synchronous mode select |
| port_en | input | 1 | Serial port enable |
| clk_master | input | 1 | Block sources the bit clock |
| tx_en | input | 1 | Transmit enable; clearing aborts a frame |
| ninth_en | input | 1 | Add a ninth bit to each frame |
| ninth_bit | input | 1 | Ninth bit value, captured on write |
| div_val | input | DIV_W | Bit-rate divider |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte written into the buffer |
| irq_en | input | 1 | Interrupt enable for buffer-empty |
| rx_busy | input | 1 | Receive side is active; hold off new frames |
| ser_clk | output | 1 | Serial bit clock line |
| ser_data | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer empty flag |
| shift_empty | output | 1 | Shift register idle status |
| irq | output | 1 | Masked buffer-empty interrupt |
| rx_block | output | 1 | Inhibit for the receive path |

## Verification
The bench builds the block with its defaults, an 8-bit data width and an 8-bit divider. It runs with divider values small enough that a full frame takes only a few dozen clocks. With divider 0 and again with divider 2, it sends all 256 byte values and compares each against the LSB-first frame it captures on the clock's rising edges. A sweep of divider settings 0 to 5 measures the high and low clock phases against 2*(div+1). Directed sequences cover the flag timing after a write, a write that waits behind a running frame, the latching of the ninth bit at write time, an abort that keeps the buffered byte, the mode gating and the receive hold-off.

// File: rtl/sync_master_tx.sv
module sync_master_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              port_en,
  input  logic              clk_master,
  input  logic              tx_en,
  input  logic              ninth_en,
  input  logic              ninth_bit,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              rx_busy,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              irq,
  output logic              rx_block
);
  localparam int FW = DATA_W + 1;
  localparam int CW = DIV_W + 1;
  localparam int BW = $clog2(FW + 1);

  logic          active, run;
  logic          buf_full, flag_q;
  logic [FW-1:0] buf_q, sh;
  logic          busy, phase;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bits_left;
  logic          load, half_end;

  assign active   = sync_mode & port_en & clk_master;
  assign run      = active & tx_en;
  assign load     = run & ~rx_busy & ~busy & buf_full;
  assign half_end = busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      flag_q   <= 1'b1;
    end else begin
      flag_q <= ~buf_full;
      if (wr_en) begin
        buf_full <= 1'b1;
        buf_q    <= {ninth_bit, wr_data};
      end else if (load) begin
        buf_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
      sh        <= '0;
    end else if (!run) begin
      busy      <= 1'b0;
      phase     <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      phase     <= 1'b0;
      cnt       <= {div_val, 1'b1};
      bits_left <= ninth_en ? BW'(FW) : BW'(DATA_W);
      sh        <= buf_q;
    end else if (half_end) begin
      cnt   <= {div_val, 1'b1};
      phase <= ~phase;
      if (phase) begin
        sh        <= sh >> 1;
        bits_left <= bits_left - 1'b1;
        if (bits_left == BW'(1)) busy <= 1'b0;
      end
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ser_clk     = busy & phase;
  assign ser_data    = busy & sh[0];
  assign buf_empty   = flag_q;
  assign shift_empty = ~busy;
  assign irq         = flag_q & irq_en;
  assign rx_block    = busy;

  p_drop_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ##2 !buf_empty);

  p_stable_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (shift_empty && !ser_clk));

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_mode && port_en && clk_master) |=> shift_empty);

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && shift_empty) |=> shift_empty);

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/tb_sync_master_tx.sv
module tb_sync_master_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 1, port_en = 1, clk_master = 1, tx_en = 1;
  logic ninth_en = 0, ninth_bit = 0, wr_en = 0, irq_en = 0, rx_busy = 0;
  logic [7:0] div_val = 0, wr_data = 0;
  logic ser_clk, ser_data, buf_empty, shift_empty, irq, rx_block;

  sync_master_tx dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic mon_clr = 0;
  logic prev_clk = 0;
  int rx_n = 0, cur_hi = 0, cur_lo = 0, last_hi = 0, last_lo = 0;
  logic [31:0] rx_word = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      rx_n <= 0; rx_word <= 0; cur_hi <= 0; cur_lo <= 0;
    end else begin
      if (ser_clk && !prev_clk) begin
        rx_word <= rx_word | (32'(ser_data) << rx_n);
        rx_n    <= rx_n + 1;
        last_lo <= cur_lo;
      end
      if (!ser_clk && prev_clk) last_hi <= cur_hi;
      cur_hi <= ser_clk ? (prev_clk ? cur_hi + 1 : 1) : 0;
      cur_lo <= (!ser_clk && !shift_empty) ? (prev_clk ? 1 : cur_lo + 1) : 0;
    end
    prev_clk <= ser_clk;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clr();
    mon_clr = 1; tick(1); mon_clr = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1; wr_data = v; tick(1); wr_en = 0;
  endtask

  task automatic wait_frame();
    int g = 0;
    while (shift_empty && g < 50) begin tick(1); g++; end
    g = 0;
    while (!shift_empty && g < 5000) begin tick(1); g++; end
    tick(2);
  endtask

  task automatic send(input logic [7:0] v, input string req);
    clr(); wr(v); wait_frame();
    chk(rx_n == 8 && rx_word == 32'(v), req, rx_word, v);
  endtask

  initial begin
    tick(2);
    chk(buf_empty && shift_empty && !ser_clk && !irq && !rx_block, "R4 reset",
        {buf_empty, shift_empty, ser_clk, irq}, 4'b1100);
    rst_n = 1; tick(2);

    // R2: all byte values, two divider settings
    for (int d = 0; d < 3; d += 2) begin
      div_val = 8'(d);
      for (int v = 0; v < 256; v++) send(8'(v), "R2 lsb-first frame");
    end

    // R3: phase widths over divider sweep
    for (int d = 0; d < 6; d++) begin
      div_val = 8'(d);
      send(8'hA5, "R2 frame");
      chk(last_hi == 2 * (d + 1), "R3 high phase", last_hi, 2 * (d + 1));
      chk(last_lo == 2 * (d + 1), "R3 low phase", last_lo, 2 * (d + 1));
      chk(!ser_clk, "R3 idle low", ser_clk, 0);
    end
    div_val = 0;

    // R4/R6: flag timing with transmit held off
    tx_en = 0; irq_en = 1; tick(2);
    wr(8'h3C);
    chk(buf_empty, "R4 not cleared at once", buf_empty, 1);
    chk(irq, "R6 irq follows flag", irq, 1);
    tick(1);
    chk(!buf_empty, "R4 cleared after second edge", buf_empty, 0);
    chk(!irq, "R6 irq low with flag", irq, 0);
    tick(5);
    chk(!buf_empty && shift_empty, "R1 held while disabled", {buf_empty, shift_empty}, 2'b01);
    irq_en = 0;
    // R5: enabling starts transfer, flag returns one clock after move
    clr(); tx_en = 1; tick(1);
    chk(!shift_empty && rx_block, "R7 R10 busy after move", {shift_empty, rx_block}, 2'b01);
    chk(!buf_empty, "R5 flag lags move", buf_empty, 0);
    tick(1);
    chk(buf_empty && !irq, "R5 flag set / R6 masked", {buf_empty, irq}, 2'b10);
    wait_frame();
    chk(rx_n == 8 && rx_word == 32'h3C, "R5 frame", rx_word, 32'h3C);

    // R5: write during frame waits, back-to-back
    clr(); wr(8'h81); tick(4); wr(8'h7E); tick(6);
    chk(!buf_empty && !shift_empty, "R5 waits behind frame", {buf_empty, shift_empty}, 2'b00);
    wait_frame();
    wait_frame();
    chk(rx_n == 16 && rx_word == 32'h7E81, "R5 back-to-back", rx_word, 32'h7E81);

    // R8: ninth bit latched at write
    tx_en = 0; ninth_en = 1; ninth_bit = 1; tick(1);
    clr(); wr(8'h5A); ninth_bit = 0; tick(2); tx_en = 1;
    wait_frame();
    chk(rx_n == 9 && rx_word == 32'h15A, "R8 ninth bit", rx_word, 32'h15A);
    ninth_en = 0;

    // R9: abort keeps buffered byte
    div_val = 3; clr(); wr(8'hF0); tick(3); wr(8'h0F); tick(10);
    tx_en = 0; tick(1);
    chk(shift_empty && !ser_clk, "R9 abort", {shift_empty, ser_clk}, 2'b10);
    tick(3);
    chk(!buf_empty, "R9 buffer kept", buf_empty, 0);
    clr(); tx_en = 1; wait_frame();
    chk(rx_n == 8 && rx_word == 32'h0F, "R9 resend after abort", rx_word, 32'h0F);
    div_val = 0;

    // R1: each mode control gates start
    for (int m = 0; m < 3; m++) begin
      sync_mode = (m != 0); port_en = (m != 1); clk_master = (m != 2);
      clr(); wr(8'h55); tick(30);
      chk(rx_n == 0 && shift_empty, "R1 gated", rx_n, 0);
      sync_mode = 1; port_en = 1; clk_master = 1;
      wait_frame();
      chk(rx_n == 8 && rx_word == 32'h55, "R1 released", rx_word, 32'h55);
    end

    // R10: receive hold-off
    rx_busy = 1; clr(); wr(8'hC3); tick(30);
    chk(rx_n == 0 && shift_empty && !rx_block, "R10 hold-off", rx_n, 0);
    rx_busy = 0; wait_frame();
    chk(rx_n == 8 && rx_word == 32'hC3, "R10 after release", rx_word, 32'hC3);

    summary();
  end
endmodule